// File: doc/BRIEF.md
# Second-Order Carrier Loop Filter

This block sits between the phase detector and the numerically controlled oscillator of a second-order carrier-tracking loop. Each accepted phase-error sample `x[n]` moves a signed correction accumulator by `x[n] - 0.09*x[n-1]`. The block then adds that correction to a fixed nominal frequency word. The result is the 32-bit tuning word that drives the oscillator.

The correction is bounded to a window of ±400 kHz around the nominal carrier. The window is given as a phase-increment count at a 125 MHz oscillator clock, which is ±13743895. At the bound the accumulator saturates rather than wraps, so it cannot wind up. It leaves the bound as soon as the error turns around.

Samples enter on a valid/ready stream, and tuning words leave on another one. A new sample is accepted only when the output slot is empty or is being drained in the same cycle. When the downstream side holds ready low, the input side therefore stalls. No sample is dropped and none is counted twice.

Top module: `pll2_loop_filter`

## Requirements
- R1: After reset `tune_valid` is 0, `tune_word` equals the nominal word (default 32'h2000_0000), and both the previous-sample register and the correction accumulator are 0.
- R2: A sample is accepted in a cycle where `err_valid` and `err_ready` are both 1. Here `err_ready` = !`tune_valid` || `tune_ready`.
- R3: On acceptance the accumulator becomes acc + x[n] + w, where w = (x[n-1] * -2949 + 16384) >>> 15. This is the product with the Q1.15 weight -2949/32768, rounded to nearest with ties toward +infinity.
- R4: On acceptance the previous-sample register loads the accepted error, and this value is used as x[n-1] by the next acceptance.
- R5: The accumulator is clamped to the range -13743895 to +13743895, which is round(400e3 * 2^32 / 125e6). It saturates rather than wraps, so the next acceptance starts from the bound.
- R6: `tune_word` equals the nominal word plus the accumulator, in 32-bit two's complement. It therefore stays within nominal ± 13743895.
- R7: `tune_valid` is 1 in the cycle after an acceptance. While `tune_valid` is 1 and `tune_ready` is 0, `tune_valid` stays 1 and `tune_word` stays unchanged.
- R8: In a cycle with no acceptance, neither the accumulator nor the previous-sample register changes. `tune_valid` falls after a cycle with `tune_ready` high and no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_sample | input | 29 | Signed phase-error sample |
| err_valid | input | 1 | Error sample present |
| err_ready | output | 1 | Block can take a sample this cycle |
| tune_word | output | 32 | Oscillator tuning word |
| tune_valid | output | 1 | Tuning word holds a fresh result |
| tune_ready | input | 1 | Downstream takes the tuning word |

## Verification
Saturation and the weighted previous-sample term can fall in the same cycle. This happens when a full-scale error of one sign follows a full-scale error of the other sign. The bench drives that pair with the accumulator already pinned at one bound. It then checks that the result lands exactly on the opposite bound. One more sample of zero must move the word off the bound by exactly the rounded weighted term, which shows the accumulator did not wrap or wind up. Acceptance and output back-pressure also meet in one cycle: the bench holds the input valid while `tune_ready` is low and checks that exactly one update occurs.

// File: rtl/pll2_lf_pkg.sv
package pll2_lf_pkg;

  // Tuning-word count that corresponds to a frequency offset, rounded to nearest.
  function automatic longint window_count(input longint range_hz, input longint ref_hz,
                                          input int word_w);
    longint scaled;
    scaled = range_hz <<< word_w;
    return (scaled + ref_hz / 2) / ref_hz;
  endfunction

  typedef enum logic [0:0] {
    RND_NEAREST  = 1'b0,
    RND_TRUNCATE = 1'b1
  } rnd_mode_e;

endpackage

// File: rtl/pll2_lf_weight.sv
module pll2_lf_weight
  import pll2_lf_pkg::*;
#(
  parameter int        ERR_W  = 29,
  parameter int        COEF_W = 16,
  parameter int        FRAC   = 15,
  parameter int        COEF   = -2949,
  parameter rnd_mode_e RND    = RND_NEAREST
) (
  input  logic signed [ERR_W-1:0] prev_i,
  output logic signed [ERR_W-1:0] term_o
);
  localparam int PW = ERR_W + COEF_W;
  localparam logic signed [COEF_W-1:0] COEF_V = COEF_W'(COEF);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] adj;

  always_comb prod = PW'(prev_i) * PW'(COEF_V);

  generate
    if (RND == RND_NEAREST) begin : g_round
      always_comb adj = prod + (PW'(1) <<< (FRAC - 1));
    end else begin : g_trunc
      always_comb adj = prod;
    end
  endgenerate

  logic signed [PW-1:0] shifted;
  always_comb shifted = adj >>> FRAC;
  assign term_o = ERR_W'(shifted);

  // |term| can never exceed |prev| for a coefficient below one in magnitude
  always_comb begin
    assert_term_bounded_R3: assert ((term_o >= 0 ? term_o : -term_o) <=
                                    (prev_i >= 0 ? prev_i : -prev_i) + 1)
      else $error("weighted term exceeds input magnitude");
  end
endmodule

// File: rtl/pll2_lf_hold.sv
module pll2_lf_hold #(
  parameter int ERR_W = 29
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic signed [ERR_W-1:0] d_i,
  output logic signed [ERR_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_prev_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> q_o == $past(d_i))
    else $error("previous-sample register did not load");

  assert_prev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o))
    else $error("previous-sample register moved without a load");
endmodule

// File: rtl/pll2_lf_accum.sv
module pll2_lf_accum #(
  parameter int     ERR_W  = 29,
  parameter int     CTRL_W = 32,
  parameter longint LIMIT  = 13743895
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  logic signed [ERR_W-1:0]  cur_i,
  input  logic signed [ERR_W-1:0]  term_i,
  output logic signed [CTRL_W-1:0] acc_o
);
  localparam int SW = CTRL_W + 2;
  localparam logic signed [SW-1:0] HI = SW'(LIMIT);
  localparam logic signed [SW-1:0] LO = -SW'(LIMIT);

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] bounded;

  always_comb begin
    sum = SW'(acc_o) + SW'(cur_i) + SW'(term_i);
    if (sum > HI)      bounded = HI;
    else if (sum < LO) bounded = LO;
    else               bounded = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_o <= '0;
    else if (step_i) acc_o <= CTRL_W'(bounded);
  end

  assert_acc_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o <= CTRL_W'(LIMIT)) && (acc_o >= -CTRL_W'(LIMIT)))
    else $error("accumulator left its window");

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(acc_o))
    else $error("accumulator moved without a step");
endmodule

// File: rtl/pll2_loop_filter.sv
module pll2_loop_filter
  import pll2_lf_pkg::*;
#(
  parameter int          ERR_W    = 29,
  parameter int          CTRL_W   = 32,
  parameter int          COEF_W   = 16,
  parameter int          FRAC     = 15,
  parameter int          COEF     = -2949,
  parameter longint      RANGE_HZ = 400000,
  parameter longint      REF_HZ   = 125000000,
  parameter logic [31:0] NOMINAL  = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_W-1:0]  err_sample,
  input  logic              err_valid,
  output logic              err_ready,
  output logic [CTRL_W-1:0] tune_word,
  output logic              tune_valid,
  input  logic              tune_ready
);
  localparam longint LIMIT = window_count(RANGE_HZ, REF_HZ, CTRL_W);

  logic                     take;
  logic signed [ERR_W-1:0]  prev_q;
  logic signed [ERR_W-1:0]  term;
  logic signed [CTRL_W-1:0] acc;

  assign err_ready = !tune_valid || tune_ready;
  assign take      = err_valid && err_ready;

  pll2_lf_hold #(.ERR_W(ERR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(take),
    .d_i($signed(err_sample)), .q_o(prev_q)
  );

  pll2_lf_weight #(
    .ERR_W(ERR_W), .COEF_W(COEF_W), .FRAC(FRAC), .COEF(COEF), .RND(RND_NEAREST)
  ) u_weight (
    .prev_i(prev_q), .term_o(term)
  );

  pll2_lf_accum #(.ERR_W(ERR_W), .CTRL_W(CTRL_W), .LIMIT(LIMIT)) u_accum (
    .clk(clk), .rst_n(rst_n), .step_i(take),
    .cur_i($signed(err_sample)), .term_i(term), .acc_o(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          tune_valid <= 1'b0;
    else if (take)       tune_valid <= 1'b1;
    else if (tune_ready) tune_valid <= 1'b0;
  end

  assign tune_word = CTRL_W'(NOMINAL) + CTRL_W'(acc);

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tune_valid)
    else $error("tune_valid missing after acceptance");

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_valid && !tune_ready) |=> (tune_valid && $stable(tune_word)))
    else $error("output changed while stalled");

  assert_no_take_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_valid && !tune_ready) |-> !err_ready)
    else $error("input ready during output stall");

  assert_word_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tune_word - CTRL_W'(NOMINAL)) <= CTRL_W'(LIMIT)) ||
    ((CTRL_W'(NOMINAL) - tune_word) <= CTRL_W'(LIMIT)))
    else $error("tuning word outside window");
endmodule

// File: tb/pll2_loop_filter_tb_top.sv
module pll2_loop_filter_tb_top;
  localparam longint NOM = 32'h2000_0000;
  localparam longint LIM = 13743895;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [28:0] err_sample = '0;
  logic        err_valid = 1'b0;
  logic        err_ready;
  logic [31:0] tune_word;
  logic        tune_valid;
  logic        tune_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll2_loop_filter dut_i (
    .clk(clk), .rst_n(rst_n), .err_sample(err_sample), .err_valid(err_valid),
    .err_ready(err_ready), .tune_word(tune_word), .tune_valid(tune_valid),
    .tune_ready(tune_ready)
  );

  // stimulus x, expected accumulator after acceptance (hand-derived from R3)
  localparam int NV = 6;
  localparam longint VEC [NV][2] = '{
    '{1000, 1000}, '{1000, 1910}, '{-500, 1320},
    '{0, 1365},    '{7, 1372},    '{0, 1371}
  };

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint word_of(input longint acc);
    return (NOM + acc) & 64'hFFFF_FFFF;
  endfunction

  // one accepted sample with tune_ready high; sample one step after the edge
  task automatic push(input longint x);
    @(negedge clk);
    err_sample = 29'(x);
    err_valid  = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 word", tune_word, NOM);
    check("R1 valid", tune_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      push(VEC[i][0]);
      check("R3 table", tune_word, word_of(VEC[i][1]));
      check("R7 valid", tune_valid, 1);
    end

    // idle cycle with garbage on the data lines: nothing moves (R8)
    @(negedge clk);
    err_sample = 29'h0ABC_DEF;
    @(posedge clk); #1;
    check("R8 idle word", tune_word, word_of(1371));
    check("R8 valid drop", tune_valid, 0);

    // upper saturation and anti-windup
    push(268435455);
    check("R5 high clamp", tune_word, word_of(LIM));
    push(268435455);
    check("R5 high stays", tune_word, word_of(LIM));
    push(-268435456);
    check("R5 low clamp with weighted term", tune_word, word_of(-LIM));
    push(0);
    check("R5 leaves bound (R4 prev used)", tune_word, word_of(-LIM + 24158208));

    // back-pressure: one acceptance only while stalled (R2, R7)
    @(negedge clk);
    tune_ready = 1'b0;
    err_sample = 29'd5;
    err_valid  = 1'b1;
    @(posedge clk); #1;
    check("R2 accept into empty slot", tune_word, word_of(-LIM + 24158208 + 5));
    repeat (4) begin
      @(posedge clk); #1;
    end
    check("R7 stall word", tune_word, word_of(-LIM + 24158208 + 5));
    check("R7 stall valid", tune_valid, 1);
    check("R2 ready low", err_ready, 0);
    @(negedge clk);
    tune_ready = 1'b1;
    @(posedge clk); #1;
    check("R2 accept on drain", tune_word, word_of(-LIM + 24158208 + 10));
    @(negedge clk);
    err_valid = 1'b0;

    // reset in mid-run returns to the nominal word
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset word", tune_word, NOM);
    check("R1 reset valid", tune_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    push(1000);
    check("R4 prev cleared by reset", tune_word, word_of(1000));
    push(0);
    check("R3 rounding with fresh prev", tune_word, word_of(1000 - 90));
    done = 1'b1;
  end

  initial begin : watchdog
    for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule